// File: doc/BRIEF.md
# Power-Down Mode Unlock Sequence Detector

This block sits on the memory side of an asynchronous-style SRAM interface with a 21-bit word address. It turns chip-enable low periods into completed access events. Each event is taken when chip enable returns high, so every access is separated by standby. The events are forwarded to a register-file style array port. While this happens, the block watches for a six-access unlock pattern:

- a read of the top address;
- two writes to the top address that return the data just read;
- two further writes to the top address whose data is ignored;
- a final read whose address acts as a key.

The key picks one of three power-down modes: full sleep, a 4M-bit retained window or an 8M-bit retained window.

A separate active-low power-down enable puts the memory into power-down while it is low. On each entry, the block records how much of the array can no longer be trusted. It keeps the worst loss seen since reset on a two-bit output, so a bench or array model can treat words outside the retained window as invalid after wake-up.

Stray accesses cancel the pattern. Whether a cancelled write still reaches the array depends on the step at which it occurred. Writes in the two data-don't-care steps never reach the array.

Top module: `pdm_unlock_top`

## Requirements
- R1: An access completes only when `mem_ce_n` returns high. It uses the type, address and data presented on the last clock edge at which `mem_ce_n` was low, so one low period yields exactly one access.
- R2: A completed write outside the unlock steps 4 and 5 pulses `arr_we` for one clock in the cycle after completion, with `arr_addr`/`arr_wdata` equal to the access. A completed read pulses `arr_re`.
- R3: The full pattern ending in a read of key 17FFFFh sets `mode` to 2'b01 (4M-bit window, words 00000h–3FFFFh retained). The new value is visible two clock edges after the final access completes.
- R4: Key 0FFFFFh sets `mode` to 2'b10 (8M-bit window, 00000h–7FFFFh). Key 1FFFFFh sets 2'b00 (sleep, nothing retained). `mode` never takes 2'b11.
- R5: In steps 2 and 3, a write to another address, or a write whose data differs from the step-1 read data, cancels the pattern. That write is still committed to the array.
- R6: Writes in steps 4 and 5 are never committed. A write in either step to an address other than 1FFFFFh cancels the pattern.
- R7: A final read from an address that is none of the three keys cancels the pattern and leaves `mode` unchanged.
- R8: An access of the wrong type for its step returns the detector to idle. That access is handled as a normal access. A read does not restart the pattern.
- R9: After reset, `mode` is 2'b00, `lost_lvl` is 2'b00, `pd_active` is 0 and neither array strobe is active.
- R10: `pd_active` follows the inverse of `pd_en_n` one clock later. While it is high, completed accesses produce no array strobe and do not advance the pattern.
- R11: On each power-down entry, `lost_lvl` becomes the larger of its current value and the loss of the current mode. The encodings are: 2'b11 for sleep (all lost), 2'b10 for the 4M-bit window (words from 40000h lost) and 2'b01 for the 8M-bit window (words from 80000h lost). 2'b00 means nothing lost. The value never decreases except on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_ce_n | input | 1 | Chip enable, low during an access |
| mem_we_n | input | 1 | Low for a write access |
| mem_addr | input | 21 | Word address |
| mem_wdata | input | 16 | Write data |
| pd_en_n | input | 1 | Power-down enable, low enters power-down |
| arr_rdata | input | 16 | Data returned by the array for `arr_addr` |
| arr_we | output | 1 | Array write strobe |
| arr_re | output | 1 | Array read strobe |
| arr_addr | output | 21 | Array address |
| arr_wdata | output | 16 | Array write data |
| mode | output | 2 | Programmed power-down mode |
| pd_active | output | 1 | Memory is in power-down |
| lost_lvl | output | 2 | Worst data-loss level since reset |

## Verification
The bench builds the block with its default widths: a 21-bit address and 16-bit data. This makes the three real keys 1FFFFFh, 17FFFFh and 0FFFFFh reachable, together with the exact step-1 read data, which the bench array model derives from the address. With these values, every cancel point is reached with the true key layout: wrong address, wrong data, wrong type and wrong key. The same holds for the nested loss levels across repeated power-down entries in different modes.

// File: rtl/pdm_pkg.sv
package pdm_pkg;

  typedef enum logic [1:0] {
    MODE_SLEEP = 2'b00,
    MODE_P4    = 2'b01,
    MODE_P8    = 2'b10
  } pd_mode_e;

  // steps of the unlock pattern already accepted
  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_RD1  = 3'd1,
    SQ_WB1  = 3'd2,
    SQ_WB2  = 3'd3,
    SQ_WX1  = 3'd4,
    SQ_WX2  = 3'd5
  } seq_state_e;

  localparam logic [1:0] LOSS_NONE = 2'b00;
  localparam logic [1:0] LOSS_HI8  = 2'b01;
  localparam logic [1:0] LOSS_HI4  = 2'b10;
  localparam logic [1:0] LOSS_ALL  = 2'b11;

  function automatic logic [1:0] loss_of(input pd_mode_e m);
    case (m)
      MODE_P4: loss_of = LOSS_HI4;
      MODE_P8: loss_of = LOSS_HI8;
      default: loss_of = LOSS_ALL;
    endcase
  endfunction

endpackage

// File: rtl/pdm_acc_capture.sv
module pdm_acc_capture #(
  parameter int AW = 21,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          evt,
  output logic          evt_we,
  output logic [AW-1:0] evt_addr,
  output logic [DW-1:0] evt_wdata
);

  logic          ce_n_q;
  logic          evt_q, evt_d;
  logic          cap_en;
  logic          we_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  always_comb begin
    cap_en = ~ce_n;
    evt_d  = ce_n & ~ce_n_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n_q <= 1'b1;
      evt_q  <= 1'b0;
    end else begin
      ce_n_q <= ce_n;
      evt_q  <= evt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      we_q    <= ~we_n;
      addr_q  <= addr;
      wdata_q <= wdata;
    end
  end

  assign evt       = evt_q;
  assign evt_we    = we_q;
  assign evt_addr  = addr_q;
  assign evt_wdata = wdata_q;

endmodule

// File: rtl/pdm_seq_fsm.sv
module pdm_seq_fsm
  import pdm_pkg::*;
#(
  parameter int AW = 21,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt,
  input  logic          evt_we,
  input  logic [AW-1:0] evt_addr,
  input  logic [DW-1:0] evt_wdata,
  input  logic [DW-1:0] rdata,
  input  logic          pd_active,
  output logic          hold_wr,
  output logic          set_vld,
  output pd_mode_e      set_mode
);

  localparam logic [AW-1:0] ONE     = {{(AW-1){1'b0}}, 1'b1};
  localparam logic [AW-1:0] KEY_TOP = {AW{1'b1}};
  localparam logic [AW-1:0] KEY_P4  = KEY_TOP ^ (ONE << (AW-2));
  localparam logic [AW-1:0] KEY_P8  = KEY_TOP ^ (ONE << (AW-1));

  seq_state_e    st_q, st_d;
  logic [DW-1:0] rda_q;
  logic          rda_en;
  logic          at_top, wr_top, wr_back, rd_op;

  always_comb begin
    at_top   = (evt_addr == KEY_TOP);
    rd_op    = evt & ~evt_we;
    wr_top   = evt & evt_we & at_top;
    wr_back  = wr_top & (evt_wdata == rda_q);
    rda_en   = (st_q == SQ_IDLE) & rd_op & at_top;
    hold_wr  = (st_q == SQ_WB2) | (st_q == SQ_WX1);
    set_vld  = 1'b0;
    set_mode = MODE_SLEEP;
    st_d     = st_q;
    if (pd_active) begin
      st_d = SQ_IDLE;
    end else if (evt) begin
      st_d = SQ_IDLE;
      case (st_q)
        SQ_IDLE: if (rd_op & at_top) st_d = SQ_RD1;
        SQ_RD1:  if (wr_back) st_d = SQ_WB1;
        SQ_WB1:  if (wr_back) st_d = SQ_WB2;
        SQ_WB2:  if (wr_top) st_d = SQ_WX1;
        SQ_WX1:  if (wr_top) st_d = SQ_WX2;
        SQ_WX2: begin
          if (rd_op) begin
            if (evt_addr == KEY_TOP) begin
              set_vld = 1'b1; set_mode = MODE_SLEEP;
            end else if (evt_addr == KEY_P4) begin
              set_vld = 1'b1; set_mode = MODE_P4;
            end else if (evt_addr == KEY_P8) begin
              set_vld = 1'b1; set_mode = MODE_P8;
            end
          end
        end
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (rda_en) rda_q <= rdata;
  end

endmodule

// File: rtl/pdm_mode_ctl.sv
module pdm_mode_ctl
  import pdm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     set_vld,
  input  pd_mode_e set_mode,
  input  logic     pd_en_n,
  output pd_mode_e mode,
  output logic     pd_active,
  output logic     [1:0] lost_lvl
);

  pd_mode_e   mode_q, mode_d;
  logic       pd_n_q;
  logic       entry;
  logic [1:0] lost_q, lost_d, new_loss;

  always_comb begin
    entry    = pd_n_q & ~pd_en_n;
    new_loss = loss_of(mode_q);
    mode_d   = set_vld ? set_mode : mode_q;
    lost_d   = lost_q;
    if (entry && (new_loss > lost_q)) lost_d = new_loss;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_SLEEP;
      pd_n_q <= 1'b1;
      lost_q <= LOSS_NONE;
    end else begin
      mode_q <= mode_d;
      pd_n_q <= pd_en_n;
      lost_q <= lost_d;
    end
  end

  assign mode      = mode_q;
  assign pd_active = ~pd_n_q;
  assign lost_lvl  = lost_q;

endmodule

// File: rtl/pdm_unlock_top.sv
module pdm_unlock_top
  import pdm_pkg::*;
#(
  parameter int AW = 21,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mem_ce_n,
  input  logic          mem_we_n,
  input  logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_wdata,
  input  logic          pd_en_n,
  input  logic [DW-1:0] arr_rdata,
  output logic          arr_we,
  output logic          arr_re,
  output logic [AW-1:0] arr_addr,
  output logic [DW-1:0] arr_wdata,
  output logic [1:0]    mode,
  output logic          pd_active,
  output logic [1:0]    lost_lvl
);

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          evt, evt_we, hold_wr, set_vld, evt_ok;
  logic [AW-1:0] evt_addr;
  logic [DW-1:0] evt_wdata;
  pd_mode_e      set_mode, mode_e;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pdm_acc_capture #(.AW(AW), .DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_int_n), .ce_n(mem_ce_n), .we_n(mem_we_n),
    .addr(mem_addr), .wdata(mem_wdata), .evt(evt), .evt_we(evt_we),
    .evt_addr(evt_addr), .evt_wdata(evt_wdata)
  );

  pdm_seq_fsm #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .evt(evt_ok), .evt_we(evt_we),
    .evt_addr(evt_addr), .evt_wdata(evt_wdata), .rdata(arr_rdata),
    .pd_active(pd_active), .hold_wr(hold_wr), .set_vld(set_vld),
    .set_mode(set_mode)
  );

  pdm_mode_ctl u_mode (
    .clk(clk), .rst_n(rst_int_n), .set_vld(set_vld), .set_mode(set_mode),
    .pd_en_n(pd_en_n), .mode(mode_e), .pd_active(pd_active),
    .lost_lvl(lost_lvl)
  );

  assign evt_ok    = evt & ~pd_active;
  assign arr_we    = evt_ok & evt_we & ~hold_wr;
  assign arr_re    = evt_ok & ~evt_we;
  assign arr_addr  = evt_addr;
  assign arr_wdata = evt_wdata;
  assign mode      = mode_e;

endmodule

// File: rtl/pdm_unlock_chk.sv
module pdm_unlock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mem_ce_n,
  input logic       arr_we,
  input logic       arr_re,
  input logic [1:0] mode,
  input logic       pd_active,
  input logic [1:0] lost_lvl
);

  // R1
  ce_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we || arr_re) |-> ($past(mem_ce_n) && !$past(mem_ce_n, 2)));

  // R2
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arr_we, arr_re}));

  // R3
  mode_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode) |-> $past(arr_re));

  // R4
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11);

  // R10
  pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_active |-> (!arr_we && !arr_re));

  // R11
  lost_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (lost_lvl >= $past(lost_lvl)));

  // R11
  lost_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lost_lvl) |-> $rose(pd_active));

endmodule

bind pdm_unlock_top pdm_unlock_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_ce_n(mem_ce_n), .arr_we(arr_we),
  .arr_re(arr_re), .mode(mode), .pd_active(pd_active), .lost_lvl(lost_lvl)
);

// File: tb/tb_pdm_unlock_top.sv
`timescale 1ns/1ps
module tb_pdm_unlock_top;

  localparam logic [20:0] TOP = 21'h1FFFFF;
  localparam logic [15:0] RDA = 16'hA5C3;  // bench array: rdata = addr[15:0] ^ 5A3C

  typedef struct packed {
    logic        we;
    logic [20:0] addr;
    logic [15:0] wd;
    logic        ec;
    logic [1:0]  em;
  } vec_t;

  localparam int NV = 44;
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b1, 21'h000010, 16'h1234, 1'b1, 2'd0},  // R2 normal write
    '{1'b0, TOP, 16'h0, 1'b0, 2'd0},            // R3 pattern to 4M
    '{1'b1, TOP, RDA, 1'b1, 2'd0},
    '{1'b1, TOP, RDA, 1'b1, 2'd0},
    '{1'b1, TOP, 16'h0000, 1'b0, 2'd0},
    '{1'b1, TOP, 16'hFFFF, 1'b0, 2'd0},
    '{1'b0, 21'h17FFFF, 16'h0, 1'b0, 2'd1},
    '{1'b0, TOP, 16'h0, 1'b0, 2'd1},            // R5 wrong addr step 2
    '{1'b1, 21'h000020, RDA, 1'b1, 2'd1},
    '{1'b1, TOP, RDA, 1'b1, 2'd1},
    '{1'b0, TOP, 16'h0, 1'b0, 2'd1},            // R5 wrong data step 3
    '{1'b1, TOP, RDA, 1'b1, 2'd1},
    '{1'b1, TOP, 16'h1111, 1'b1, 2'd1},
    '{1'b1, TOP, 16'h0000, 1'b1, 2'd1},
    '{1'b0, TOP, 16'h0, 1'b0, 2'd1},            // R6 wrong addr step 4
    '{1'b1, TOP, RDA, 1'b1, 2'd1},
    '{1'b1, TOP, RDA, 1'b1, 2'd1},
    '{1'b1, 21'h000030, 16'h7777, 1'b0, 2'd1},
    '{1'b0, 21'h0FFFFF, 16'h0, 1'b0, 2'd1},
    '{1'b0, TOP, 16'h0, 1'b0, 2'd1},            // R7 bad key
    '{1'b1, TOP, RDA, 1'b1, 2'd1},
    '{1'b1, TOP, RDA, 1'b1, 2'd1},
    '{1'b1, TOP, 16'h0, 1'b0, 2'd1},
    '{1'b1, TOP, 16'h0, 1'b0, 2'd1},
    '{1'b0, 21'h000000, 16'h0, 1'b0, 2'd1},
    '{1'b0, TOP, 16'h0, 1'b0, 2'd1},            // R8 read at step 2
    '{1'b0, TOP, 16'h0, 1'b0, 2'd1},
    '{1'b1, TOP, RDA, 1'b1, 2'd1},
    '{1'b0, TOP, 16'h0, 1'b0, 2'd1},            // R4 pattern to 8M
    '{1'b1, TOP, RDA, 1'b1, 2'd1},
    '{1'b1, TOP, RDA, 1'b1, 2'd1},
    '{1'b1, TOP, 16'h0BAD, 1'b0, 2'd1},
    '{1'b1, TOP, 16'h0000, 1'b0, 2'd1},
    '{1'b0, 21'h0FFFFF, 16'h0, 1'b0, 2'd2},
    '{1'b0, TOP, 16'h0, 1'b0, 2'd2},            // R4 pattern to sleep
    '{1'b1, TOP, RDA, 1'b1, 2'd2},
    '{1'b1, TOP, RDA, 1'b1, 2'd2},
    '{1'b1, TOP, 16'h0, 1'b0, 2'd2},
    '{1'b1, TOP, 16'h0, 1'b0, 2'd2},
    '{1'b0, TOP, 16'h0, 1'b0, 2'd0},
    '{1'b0, TOP, 16'h0, 1'b0, 2'd0},            // R5 wrong data step 2
    '{1'b1, TOP, 16'h5555, 1'b1, 2'd0},
    '{1'b1, TOP, RDA, 1'b1, 2'd0},
    '{1'b1, 21'h000040, 16'hBEEF, 1'b1, 2'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mem_ce_n, mem_we_n, pd_en_n;
  logic [20:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] arr_rdata;
  logic        arr_we, arr_re, pd_active;
  logic [20:0] arr_addr;
  logic [15:0] arr_wdata;
  logic [1:0]  mode, lost_lvl;

  int n_chk = 0;
  int n_bad = 0;
  logic        got_c, got_r;
  logic [20:0] got_a;
  logic [15:0] got_d;

  always #4 clk = ~clk;

  assign arr_rdata = arr_addr[15:0] ^ 16'h5A3C;

  pdm_unlock_top dut (
    .clk(clk), .rst_n(rst_n), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .pd_en_n(pd_en_n),
    .arr_rdata(arr_rdata), .arr_we(arr_we), .arr_re(arr_re),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata), .mode(mode),
    .pd_active(pd_active), .lost_lvl(lost_lvl)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one access with standby after it; strobes sampled in the strobe cycle
  task automatic access(input bit we, input logic [20:0] a, input logic [15:0] d);
    mem_ce_n = 1'b0; mem_we_n = ~we; mem_addr = a; mem_wdata = d;
    @(negedge clk); mem_ce_n = 1'b1;
    @(negedge clk);
    got_c = arr_we; got_r = arr_re; got_a = arr_addr; got_d = arr_wdata;
    @(negedge clk);
  endtask

  task automatic program_mode(input logic [20:0] key);
    access(1'b0, TOP, 16'h0);
    access(1'b1, TOP, RDA);
    access(1'b1, TOP, RDA);
    access(1'b1, TOP, 16'h0);
    access(1'b1, TOP, 16'h0);
    access(1'b0, key, 16'h0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    mem_ce_n = 1'b1; mem_we_n = 1'b1; mem_addr = '0; mem_wdata = '0;
    pd_en_n = 1'b1;
    @(negedge clk);
    do_reset();
    // R9 reset state
    chk(mode == 2'd0, "R9 mode", mode, 0);
    chk(lost_lvl == 2'd0, "R9 lost_lvl", lost_lvl, 0);
    chk(!pd_active && !arr_we && !arr_re, "R9 idle outputs",
        {pd_active, arr_we, arr_re}, 0);

    // table walk: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      access(VEC[i].we, VEC[i].addr, VEC[i].wd);
      chk(got_c == VEC[i].ec, $sformatf("R2/R5/R6 commit vec %0d", i), got_c, VEC[i].ec);
      if (VEC[i].ec)
        chk(got_a == VEC[i].addr && got_d == VEC[i].wd,
            $sformatf("R2 write fields vec %0d", i), {got_a, got_d},
            {VEC[i].addr, VEC[i].wd});
      if (!VEC[i].we)
        chk(got_r == 1'b1, $sformatf("R2 read strobe vec %0d", i), got_r, 1);
      chk(mode == VEC[i].em, $sformatf("R3/R4/R7/R8 mode vec %0d", i), mode, VEC[i].em);
    end

    // R1: two addresses in one low period give one access, to the last one
    mem_ce_n = 1'b0; mem_we_n = 1'b0; mem_addr = 21'h000100; mem_wdata = 16'h0101;
    @(negedge clk);
    chk(!arr_we, "R1 no strobe while low", arr_we, 0);
    mem_addr = 21'h000200; mem_wdata = 16'h0202;
    @(negedge clk);
    chk(!arr_we, "R1 no strobe while low", arr_we, 0);
    mem_ce_n = 1'b1;
    @(negedge clk);
    chk(arr_we && arr_addr == 21'h000200 && arr_wdata == 16'h0202,
        "R1 last presented access", {arr_we, arr_addr, arr_wdata},
        {1'b1, 21'h000200, 16'h0202});
    @(negedge clk);
    chk(!arr_we, "R1 single strobe", arr_we, 0);

    // R10/R11: power-down in sleep
    pd_en_n = 1'b0;
    @(negedge clk);
    chk(pd_active, "R10 pd_active", pd_active, 1);
    chk(lost_lvl == 2'b11, "R11 sleep loss", lost_lvl, 2'b11);
    access(1'b1, 21'h000050, 16'h5050);
    chk(!got_c, "R10 write ignored in power-down", got_c, 0);
    program_mode(21'h17FFFF);
    chk(mode == 2'd0, "R10 pattern ignored in power-down", mode, 0);
    pd_en_n = 1'b1;
    @(negedge clk);
    chk(!pd_active, "R10 exit", pd_active, 0);

    // R11 levels after fresh reset
    do_reset();
    chk(lost_lvl == 2'd0 && mode == 2'd0, "R9 reset clears", {lost_lvl, mode}, 0);
    program_mode(21'h0FFFFF);
    chk(mode == 2'd2, "R4 8M mode", mode, 2);
    pd_en_n = 1'b0; @(negedge clk);
    chk(lost_lvl == 2'b01, "R11 8M loss", lost_lvl, 2'b01);
    pd_en_n = 1'b1; @(negedge clk);
    program_mode(21'h17FFFF);
    chk(mode == 2'd1, "R3 4M mode", mode, 1);
    pd_en_n = 1'b0; @(negedge clk);
    chk(lost_lvl == 2'b10, "R11 4M loss", lost_lvl, 2'b10);
    pd_en_n = 1'b1; @(negedge clk);
    program_mode(21'h0FFFFF);
    pd_en_n = 1'b0; @(negedge clk);
    chk(lost_lvl == 2'b10, "R11 keeps worse loss", lost_lvl, 2'b10);
    pd_en_n = 1'b1; @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule